// File: doc/BRIEF.md
# Command-Response Buffer Address Tracker

This block follows where a serial slave engine currently stands inside a shared message buffer. The engine reads response bytes from the buffer and writes command bytes into it. When a bus transfer begins, the tracker copies two programmable base addresses into a read pointer and a write pointer. Each accepted buffer access then moves the pointer of its own kind forward by one. A pointer that reaches the last buffer address stays there and does not wrap.

Software sees both pointers, a transfer-busy flag and a bus-level busy flag in one 32-bit status word. It also gets two byte counts, each equal to a pointer minus its base. The pointer values are only settled while the transfer-busy flag is low.

All pins are plain control and status pins. The access strobes are single-cycle pulses that are always accepted. There is no valid/ready pair and no back-pressure, because the tracker never stalls the engine.

Top module: `cmdresp_addr_tracker`

## Requirements
- R1: While reset is asserted, both pointers read 0 and the transfer-busy flag reads 0. With the bus-busy input low, the status word is 0.
- R2: A start pulse loads the read pointer from the read base and the write pointer from the write base, and sets transfer-busy on the next edge. A start pulse overrides a strobe or stop that arrives in the same cycle.
- R3: While transfer-busy is 1, a read strobe raises the read pointer by exactly 1 and a write strobe raises the write pointer by exactly 1. Strobes in the same cycle update their own pointers independently.
- R4: A pointer that holds LAST_ADDR (default 511) stays at LAST_ADDR when further strobes arrive, and never exceeds LAST_ADDR.
- R5: A base above LAST_ADDR is loaded as LAST_ADDR.
- R6: Strobes that arrive while transfer-busy is 0 change neither pointer.
- R7: A stop pulse without a start clears transfer-busy on the next edge. A strobe in the stop cycle still counts, and the pointers hold afterwards.
- R8: The read count equals the read pointer minus the read base input, and the write count equals the write pointer minus the write base input, both modulo 2^PTR_W.
- R9: Status word layout: read pointer in bits 8:0, write pointer in bits 24:16, transfer-busy in bit 31, and bit 30 equal to the bus-busy input. Bits 15:9 and 29:25 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transfer start pulse |
| xfer_stop | input | 1 | Transfer stop pulse |
| bus_busy | input | 1 | Bus-level busy level, mirrored to bit 30 |
| rd_base | input | PTR_W | Read base address |
| wr_base | input | PTR_W | Write base address |
| rd_strobe | input | 1 | One buffer read access |
| wr_strobe | input | 1 | One buffer write access |
| status_word | output | 32 | Packed status |
| rd_count | output | PTR_W | Bytes read since start |
| wr_count | output | PTR_W | Bytes written since start |
| xfer_busy | output | 1 | Transfer in progress |

## Verification
The bench drives a read pointer from 509 up to the limit and keeps strobing it. A wrapping design would show 0 there, and an off-by-one limit would stop one address early. A second instance with a lower limit is given a base above that limit. A design without clamping would load the raw base, so the pointer would sit above the limit. The bench also sends strobes while idle, in the stop cycle, and in the same cycle as a start, to expose wrong gating or wrong priority. It checks count values that fall below the base, which a saturating subtractor would pin at 0.

// File: rtl/cmdresp_pkg.sv
package cmdresp_pkg;
  typedef struct packed {
    logic       xfer_busy;
    logic       bus_busy;
    logic [4:0] rsv_hi;
    logic [8:0] wr_ptr;
    logic [6:0] rsv_lo;
    logic [8:0] rd_ptr;
  } status_t;

  localparam int NUM_PTR = 2;
  localparam int IDX_RD  = 0;
  localparam int IDX_WR  = 1;
endpackage

// File: rtl/cmdresp_xfer_ctrl.sv
module cmdresp_xfer_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic rd_stb_i,
  input  logic wr_stb_i,
  output logic busy_o,
  output logic load_o,
  output logic rd_step_o,
  output logic wr_step_o
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (stop_i)  busy_q <= 1'b0;
  end

  assign busy_o    = busy_q;
  assign load_o    = start_i;
  assign rd_step_o = rd_stb_i & busy_q;
  assign wr_step_o = wr_stb_i & busy_q;

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  assert_stop_clears_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !busy_o);
  assert_idle_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(rd_step_o || wr_step_o));
endmodule

// File: rtl/cmdresp_sat_ptr.sv
module cmdresp_sat_ptr #(
  parameter int PTR_W     = 9,
  parameter int LAST_ADDR = 511
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PTR_W-1:0] base_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LAST_ADDR);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] base_cl;

  always_comb base_cl = (base_i > LAST) ? LAST : base_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                     ptr_q <= '0;
    else if (load_i)                ptr_q <= base_cl;
    else if (step_i && ptr_q < LAST) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_o != LAST) |=> ptr_o == $past(ptr_o) + 1'b1);
  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_o == LAST) |=> ptr_o == LAST);
  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o <= LAST);
  assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && base_i > LAST) |=> ptr_o == LAST);
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(ptr_o));
endmodule

// File: rtl/cmdresp_status_pack.sv
module cmdresp_status_pack
  import cmdresp_pkg::*;
#(
  parameter int PTR_W = 9
) (
  input  logic             xfer_busy_i,
  input  logic             bus_busy_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  output logic [31:0]      word_o
);
  status_t st;

  always_comb begin
    st           = '0;
    st.xfer_busy = xfer_busy_i;
    st.bus_busy  = bus_busy_i;
    st.rd_ptr    = 9'(rd_ptr_i);
    st.wr_ptr    = 9'(wr_ptr_i);
    word_o       = st;
  end
endmodule

// File: rtl/cmdresp_addr_tracker.sv
module cmdresp_addr_tracker
  import cmdresp_pkg::*;
#(
  parameter int PTR_W     = 9,
  parameter int LAST_ADDR = 511
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             xfer_stop,
  input  logic             bus_busy,
  input  logic [PTR_W-1:0] rd_base,
  input  logic [PTR_W-1:0] wr_base,
  input  logic             rd_strobe,
  input  logic             wr_strobe,
  output logic [31:0]      status_word,
  output logic [PTR_W-1:0] rd_count,
  output logic [PTR_W-1:0] wr_count,
  output logic             xfer_busy
);
  logic             load;
  logic             rd_step, wr_step;
  logic             step  [NUM_PTR];
  logic [PTR_W-1:0] base  [NUM_PTR];
  logic [PTR_W-1:0] ptr   [NUM_PTR];

  cmdresp_xfer_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (xfer_start),
    .stop_i   (xfer_stop),
    .rd_stb_i (rd_strobe),
    .wr_stb_i (wr_strobe),
    .busy_o   (xfer_busy),
    .load_o   (load),
    .rd_step_o(rd_step),
    .wr_step_o(wr_step)
  );

  assign step[IDX_RD] = rd_step;
  assign step[IDX_WR] = wr_step;
  assign base[IDX_RD] = rd_base;
  assign base[IDX_WR] = wr_base;

  for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
    cmdresp_sat_ptr #(.PTR_W(PTR_W), .LAST_ADDR(LAST_ADDR)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load),
      .base_i(base[gi]),
      .step_i(step[gi]),
      .ptr_o (ptr[gi])
    );
  end

  assign rd_count = ptr[IDX_RD] - rd_base;
  assign wr_count = ptr[IDX_WR] - wr_base;

  cmdresp_status_pack #(.PTR_W(PTR_W)) u_pack (
    .xfer_busy_i(xfer_busy),
    .bus_busy_i (bus_busy),
    .rd_ptr_i   (ptr[IDX_RD]),
    .wr_ptr_i   (ptr[IDX_WR]),
    .word_o     (status_word)
  );

  assert_idle_status_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_busy && !xfer_start) |=> (status_word[24:16] == $past(status_word[24:16])
                                     && status_word[8:0] == $past(status_word[8:0])));
  assert_load_busy_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> status_word[31]);
endmodule

// File: tb/cmdresp_addr_tracker_tb.sv
module cmdresp_addr_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st = 0, sp = 0, bb = 0, rs = 0, ws = 0;
  logic [8:0] rb = '0, wb = '0;
  logic [31:0] sw;
  logic [8:0] rc, wc;
  logic busy;

  logic l_st = 0, l_rs = 0, l_ws = 0;
  logic [8:0] l_rb = '0, l_wb = '0;
  logic [31:0] l_sw;
  logic [8:0] l_rc, l_wc;
  logic l_busy;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmdresp_addr_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(st), .xfer_stop(sp), .bus_busy(bb),
    .rd_base(rb), .wr_base(wb), .rd_strobe(rs), .wr_strobe(ws),
    .status_word(sw), .rd_count(rc), .wr_count(wc), .xfer_busy(busy));

  cmdresp_addr_tracker #(.PTR_W(9), .LAST_ADDR(300)) u_dut_lim (
    .clk(clk), .rst_n(rst_n), .xfer_start(l_st), .xfer_stop(1'b0), .bus_busy(1'b0),
    .rd_base(l_rb), .wr_base(l_wb), .rd_strobe(l_rs), .wr_strobe(l_ws),
    .status_word(l_sw), .rd_count(l_rc), .wr_count(l_wc), .xfer_busy(l_busy));

  // Vector: start, stop, rd, wr, bus_busy, rd_base, wr_base, exp_rd, exp_wr, exp_busy
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {5'b10000, 9'd10,  9'd100, 9'd10,  9'd100, 1'b1}, // R2 load
    {5'b00100, 9'd10,  9'd100, 9'd11,  9'd100, 1'b1}, // R3 read
    {5'b00010, 9'd10,  9'd100, 9'd11,  9'd101, 1'b1}, // R3 write
    {5'b00110, 9'd10,  9'd100, 9'd12,  9'd102, 1'b1}, // R3 both
    {5'b00001, 9'd10,  9'd100, 9'd12,  9'd102, 1'b1}, // R9 bus busy bit
    {5'b01100, 9'd10,  9'd100, 9'd13,  9'd102, 1'b0}, // R7 stop with strobe
    {5'b00110, 9'd10,  9'd100, 9'd13,  9'd102, 1'b0}, // R6 idle strobes
    {5'b10100, 9'd509, 9'd0,   9'd509, 9'd0,   1'b1}, // R2 start beats strobe
    {5'b00100, 9'd509, 9'd0,   9'd510, 9'd0,   1'b1}, // R3
    {5'b00110, 9'd509, 9'd0,   9'd511, 9'd1,   1'b1}, // R4 reach limit
    {5'b00100, 9'd509, 9'd0,   9'd511, 9'd1,   1'b1}, // R4 saturate
    {5'b11100, 9'd5,   9'd6,   9'd5,   9'd6,   1'b1}, // R2 start beats stop
    {5'b01000, 9'd5,   9'd6,   9'd5,   9'd6,   1'b0}  // R7 stop
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      summary();
    end
  end

  initial begin
    logic [31:0] exp_sw;
    repeat (3) @(posedge clk);
    #2;
    chk(sw == 32'h0, "R1 status", sw, 32'h0);
    chk(!busy && rc == 0 && wc == 0, "R1 busy/counts", {busy, rc, wc}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      @(negedge clk);
      st = v[41]; sp = v[40]; rs = v[39]; ws = v[38]; bb = v[37];
      rb = v[36:28]; wb = v[27:19];
      @(posedge clk); #2;
      exp_sw = {v[0], bb, 5'd0, v[9:1], 7'd0, v[18:10]};
      chk(sw == exp_sw, $sformatf("R9/R3/R4 status vec%0d", i), sw, exp_sw);
      chk(busy == v[0], $sformatf("R2/R7 busy vec%0d", i), 32'(busy), 32'(v[0]));
      chk(rc == v[18:10] - rb && wc == v[9:1] - wb, $sformatf("R8 counts vec%0d", i),
          {7'd0, rc, 7'd0, wc}, {7'd0, 9'(v[18:10] - rb), 7'd0, 9'(v[9:1] - wb)});
      @(negedge clk);
      st = 0; sp = 0; rs = 0; ws = 0;
    end

    // R8: pointer below base gives modulo difference
    @(negedge clk) rb = 9'd20;
    #1 chk(rc == 9'd497, "R8 wrap count", 32'(rc), 32'd497);

    // R5 and R4 on the limited instance
    @(negedge clk) begin l_st = 1; l_rb = 9'd400; l_wb = 9'd299; end
    @(posedge clk); #2;
    chk(l_sw[8:0] == 9'd300, "R5 clamp", 32'(l_sw[8:0]), 32'd300);
    chk(l_sw[24:16] == 9'd299, "R2 load lim", 32'(l_sw[24:16]), 32'd299);
    chk(l_rc == 9'd412, "R8 clamped count", 32'(l_rc), 32'd412);
    @(negedge clk) begin l_st = 0; l_ws = 1; l_rs = 1; end
    @(posedge clk); #2;
    chk(l_sw[24:16] == 9'd300 && l_sw[8:0] == 9'd300, "R4 lim reach", l_sw, 32'h012C012C | 32'h80000000);
    @(posedge clk); #2;
    chk(l_sw == 32'h812C012C, "R4 lim saturate", l_sw, 32'h812C012C);
    @(negedge clk) begin l_ws = 0; l_rs = 0; end

    // R1: reset mid-run
    @(negedge clk) begin rst_n = 0; bb = 0; end
    @(posedge clk); #2;
    chk(sw == 32'h0, "R1 reset midrun", sw, 32'h0);
    chk(l_sw == 32'h0, "R1 reset lim", l_sw, 32'h0);

    done = 1;
    summary();
  end
endmodule